// File: doc/BRIEF.md
# Register Write Commit Monitor

This block sits next to an APB subordinate and watches both the bus and the subordinate's own write path. From the bus it sees select, enable, direction, ready, address and write data. From the subordinate it taps the register write-enable and the live contents of a small bank of mapped registers. It follows every access from the setup cycle to its completion. It checks that each write lands in the register file exactly once, on the completing edge, with data and address that did not move while the access was open.

When a rule breaks, the monitor raises a sticky flag for that cause and records a 3-bit code for the first error seen. Flags stay set until a one-cycle synchronous clear. Alongside the checks, one saturating counter per mapped register counts the completed bus writes to that register's address, so coverage can show that every register was written. Register i is mapped at address `BASE + i*STRIDE`.

A bus write completion is a cycle with select, enable, write and ready all high at a rising clock edge. A commit is a bus write completion on which the subordinate write-enable is also high.

Top module: `apb_commit_monitor`

## Requirements
- R1: Subordinate write-enable high on a wait cycle (select and enable high, ready low) sets flag bit 0, cause code 1.
- R2: Subordinate write-enable high on a setup cycle (select high, enable low) sets flag bit 1, cause code 2.
- R3: A mapped register tap that differs from its value one cycle earlier sets flag bit 2, cause code 3, unless the earlier cycle was a commit to that register's address.
- R4: Flag bit 3, cause code 4, is set in two cases. The first is a bus write completion where the write-enable pulses of the access, counting setup, wait and completion cycles, do not total exactly one. The second is a write-enable pulse while select is low.
- R5: Flag bit 4, cause code 5, is set in two cases. The first is an address on any enable-high cycle of an access that differs from the one captured at setup. The second is write data at a write completion that differs from the data captured at setup.
- R6: A completion with write low and write-enable high sets flag bit 5, cause code 6.
- R7: A mapped register tap changes on the cycle after a selected write to an address that hits no mapped register. This sets flag bit 6, cause code 7, in addition to R3.
- R8: A well-formed write sets no flag, with any number of wait states and the register updating on the following cycle. So does a well-formed read.
- R9: Flags appear one cycle after the offending cycle. They hold until `err_clr` is high at a clock edge. Errors detected on the clear cycle itself survive that clear.
- R10: `err_cause` keeps the lowest code among the errors of the first erroring cycle since the last clear. Later errors do not change it. `err_valid` is high exactly when some flag is set.
- R11: The counter of register i increments on each bus write completion to `BASE + i*STRIDE`, whatever the write-enable does. It saturates at all ones.
- R12: Reset clears flags, cause, valid, counters and all captured state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| err_clr | input | 1 | One-cycle clear of the error flags and cause |
| bus_sel | input | 1 | Subordinate select |
| bus_enable | input | 1 | Access phase indicator |
| bus_write | input | 1 | Transfer direction, high for write |
| bus_ready | input | 1 | Subordinate completes the access |
| bus_addr | input | AW (8) | Transfer address |
| bus_wdata | input | DW (16) | Write data |
| sub_wen | input | 1 | Subordinate register write-enable tap |
| sub_regs | input | NREG*DW (64) | Mapped register contents, register i in bits [i*DW +: DW] |
| err_flags | output | 7 | Sticky per-cause flags, bit k for code k+1 |
| err_cause | output | 3 | Code of the first error since the last clear |
| err_valid | output | 1 | A flag is set |
| commit_cnt | output | NREG*CW (32) | Saturating write counters, register i in bits [i*CW +: CW] |

## Verification
The bench targets the wait-state case. A write-enable gated on enable alone looks correct with no wait state but fires early and twice with one. A monitor that missed this would raise only bit 3 or nothing, instead of bits 0 and 3. The bench also drives the following stimulus:
- a read completing with the write-enable high;
- a register changing during a write to an unmapped address;
- write data and address that move before completion;
- a missing commit.

Any of these would leave its flag clear on a monitor that ignored that rule. The remaining corners are flag stickiness and clear priority, first-cause retention, and counter saturation after 260 writes. A faulty design would drop flags, overwrite the first cause, or wrap the counter to a small value.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_WAIT   = 3'd1,
        CAUSE_EARLY  = 3'd2,
        CAUSE_OFFREG = 3'd3,
        CAUSE_COUNT  = 3'd4,
        CAUSE_HOLD   = 3'd5,
        CAUSE_RDWR   = 3'd6,
        CAUSE_UNMAP  = 3'd7
    } cause_e;

    localparam int NCAUSE = 7;

    // flag bit index for each cause (code minus one)
    localparam int B_WAIT   = 0;
    localparam int B_EARLY  = 1;
    localparam int B_OFFREG = 2;
    localparam int B_COUNT  = 3;
    localparam int B_HOLD   = 4;
    localparam int B_RDWR   = 5;
    localparam int B_UNMAP  = 6;

    typedef struct packed {
        logic sel;
        logic en;
        logic wr;
        logic rdy;
        logic wen;
    } bus_s;

    function automatic cause_e first_cause(input logic [NCAUSE-1:0] v);
        cause_e c;
        c = CAUSE_NONE;
        for (int k = NCAUSE - 1; k >= 0; k--) begin
            if (v[k]) c = cause_e'(3'(k + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/wcc_phase_track.sv
module wcc_phase_track
    import wcc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_s              b,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [NCAUSE-1:0] err
);

    localparam int PW = 2;
    localparam logic [PW-1:0] PMAX = '1;

    logic setup_c, access_c, wait_c, done_c, wdone_c;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic          in_acc;
    logic [PW-1:0] pulses;
    logic [PW:0]   total;

    assign setup_c  = b.sel & ~b.en;
    assign access_c = b.sel & b.en;
    assign wait_c   = access_c & ~b.rdy;
    assign done_c   = access_c & b.rdy;
    assign wdone_c  = done_c & b.wr;
    assign total    = {1'b0, pulses} + {{PW{1'b0}}, b.wen};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_data <= '0;
            in_acc   <= 1'b0;
            pulses   <= '0;
        end else if (setup_c) begin
            cap_addr <= addr;
            cap_data <= wdata;
            in_acc   <= 1'b1;
            pulses   <= {{(PW-1){1'b0}}, b.wen};
        end else if (done_c) begin
            in_acc   <= 1'b0;
            pulses   <= '0;
        end else if (access_c && b.wen && pulses != PMAX) begin
            pulses   <= pulses + 1'b1;
        end
    end

    always_comb begin
        err           = '0;
        err[B_WAIT]   = wait_c & b.wen;
        err[B_EARLY]  = setup_c & b.wen;
        err[B_COUNT]  = (wdone_c && total != 3'(1)) || (b.wen && !b.sel);
        err[B_HOLD]   = access_c & in_acc &
                        ((addr != cap_addr) || (wdone_c && wdata != cap_data));
        err[B_RDWR]   = done_c & ~b.wr & b.wen;
    end

endmodule

// File: rtl/wcc_reg_watch.sv
module wcc_reg_watch
    import wcc_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int NREG   = 4,
    parameter int BASE   = 0,
    parameter int STRIDE = 4,
    parameter int CW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 exp_commit,
    input  logic                 wen,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [NREG*DW-1:0]   taps,
    output logic [NCAUSE-1:0]    err,
    output logic [NREG*CW-1:0]   counts
);

    localparam logic [CW-1:0] CMAX = '1;

    logic [NREG-1:0] hit, changed, prev_commit;
    logic            prev_vld, prev_unmap;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [AW-1:0] RADDR = AW'(BASE + i * STRIDE);
        logic [DW-1:0] tap, prev_tap;
        logic          pc_q;
        logic [CW-1:0] cnt_q;

        assign tap            = taps[i*DW +: DW];
        assign hit[i]         = (addr == RADDR);
        assign changed[i]     = prev_vld && (tap != prev_tap);
        assign prev_commit[i] = pc_q;
        assign counts[i*CW +: CW] = cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_tap <= '0;
                pc_q     <= 1'b0;
                cnt_q    <= '0;
            end else begin
                prev_tap <= tap;
                pc_q     <= exp_commit & wen & hit[i];
                if (exp_commit && hit[i] && cnt_q != CMAX)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vld   <= 1'b0;
            prev_unmap <= 1'b0;
        end else begin
            prev_vld   <= 1'b1;
            prev_unmap <= sel & wr & ~(|hit);
        end
    end

    always_comb begin
        err           = '0;
        err[B_OFFREG] = |(changed & ~prev_commit);
        err[B_UNMAP]  = prev_unmap & (|changed);
    end

endmodule

// File: rtl/wcc_err_log.sv
module wcc_err_log
    import wcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [NCAUSE-1:0] raw,
    output logic [NCAUSE-1:0] flags,
    output cause_e            cause,
    output logic              valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            cause <= CAUSE_NONE;
            valid <= 1'b0;
        end else begin
            flags <= (clr ? '0 : flags) | raw;
            if ((clr || !valid) && (|raw)) begin
                cause <= first_cause(raw);
                valid <= 1'b1;
            end else if (clr) begin
                cause <= CAUSE_NONE;
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/apb_commit_monitor.sv
module apb_commit_monitor
    import wcc_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int NREG   = 4,
    parameter int BASE   = 0,
    parameter int STRIDE = 4,
    parameter int CW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_clr,
    input  logic                 bus_sel,
    input  logic                 bus_enable,
    input  logic                 bus_write,
    input  logic                 bus_ready,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 sub_wen,
    input  logic [NREG*DW-1:0]   sub_regs,
    output logic [NCAUSE-1:0]    err_flags,
    output logic [2:0]           err_cause,
    output logic                 err_valid,
    output logic [NREG*CW-1:0]   commit_cnt
);

    bus_s              b;
    logic              exp_commit;
    logic [NCAUSE-1:0] pt_err, rw_err;
    cause_e            cause_q;

    assign b          = '{sel: bus_sel, en: bus_enable, wr: bus_write,
                          rdy: bus_ready, wen: sub_wen};
    assign exp_commit = bus_sel & bus_enable & bus_write & bus_ready;

    wcc_phase_track #(.AW(AW), .DW(DW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .b     (b),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .err   (pt_err)
    );

    wcc_reg_watch #(
        .AW(AW), .DW(DW), .NREG(NREG), .BASE(BASE), .STRIDE(STRIDE), .CW(CW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .exp_commit (exp_commit),
        .wen        (sub_wen),
        .sel        (bus_sel),
        .wr         (bus_write),
        .addr       (bus_addr),
        .taps       (sub_regs),
        .err        (rw_err),
        .counts     (commit_cnt)
    );

    wcc_err_log u_log (
        .clk   (clk),
        .rst   (rst),
        .clr   (err_clr),
        .raw   (pt_err | rw_err),
        .flags (err_flags),
        .cause (cause_q),
        .valid (err_valid)
    );

    assign err_cause = cause_q;

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker #(
    parameter int AW     = 8,
    parameter int NREG   = 4,
    parameter int BASE   = 0,
    parameter int CW     = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               err_clr,
    input logic               bus_sel,
    input logic               bus_enable,
    input logic               bus_write,
    input logic               bus_ready,
    input logic [AW-1:0]      bus_addr,
    input logic               sub_wen,
    input logic [6:0]         err_flags,
    input logic [2:0]         err_cause,
    input logic               err_valid,
    input logic [NREG*CW-1:0] commit_cnt
);

    // R1
    a_r1_wait_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && !bus_ready && sub_wen) |=> err_flags[0]);

    // R2
    a_r2_early_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_enable && sub_wen) |=> err_flags[1]);

    // R4
    a_r4_unselected_wen: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel && sub_wen) |=> err_flags[3]);

    // R6
    a_r6_read_wen: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_enable && bus_ready && !bus_write && sub_wen) |=> err_flags[5]);

    // R9
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R10
    a_r10_valid_any: assert property (@(posedge clk) disable iff (rst)
        err_valid == (err_flags != 7'd0));

    a_r10_cause_flagged: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ((err_flags >> (err_cause - 3'd1)) & 7'd1) != 7'd0);

    // R11
    a_r11_count_on_write: assert property (@(posedge clk) disable iff (rst)
        (commit_cnt[CW-1:0] != $past(commit_cnt[CW-1:0])) |->
        $past(bus_sel && bus_enable && bus_write && bus_ready && bus_addr == AW'(BASE)));

    // R12
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (err_flags == 7'd0 && !err_valid && commit_cnt == '0));

endmodule

bind apb_commit_monitor wcc_checker #(
    .AW(AW), .NREG(NREG), .BASE(BASE), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_clr    (err_clr),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .sub_wen    (sub_wen),
    .err_flags  (err_flags),
    .err_cause  (err_cause),
    .err_valid  (err_valid),
    .commit_cnt (commit_cnt)
);

// File: tb/sim_apb_commit_monitor.sv
module sim_apb_commit_monitor;

    localparam int AW = 8, DW = 16, NREG = 4, CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic err_clr = 1'b0;
    logic sel = 1'b0, en = 1'b0, wr = 1'b0, rdy = 1'b0, wen = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] regs [NREG];
    logic [NREG*DW-1:0] sub_regs;
    logic [6:0] err_flags;
    logic [2:0] err_cause;
    logic err_valid;
    logic [NREG*CW-1:0] commit_cnt;
    int exp_cnt [NREG];
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < NREG; i++) begin : g_pack
        assign sub_regs[i*DW +: DW] = regs[i];
    end

    apb_commit_monitor u0 (
        .clk(clk), .rst(rst), .err_clr(err_clr),
        .bus_sel(sel), .bus_enable(en), .bus_write(wr), .bus_ready(rdy),
        .bus_addr(addr), .bus_wdata(wdata), .sub_wen(wen), .sub_regs(sub_regs),
        .err_flags(err_flags), .err_cause(err_cause), .err_valid(err_valid),
        .commit_cnt(commit_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_err(input string tag, input logic [6:0] f, input logic [2:0] c);
        chk({tag, " flags"}, 32'(err_flags), 32'(f));
        chk({tag, " cause"}, 32'(err_cause), 32'(c));
        chk({tag, " valid"}, 32'(err_valid), 32'(f != 0));
    endtask

    task automatic chk_cnt(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, 32'(commit_cnt[i*CW +: CW]), 32'(exp_cnt[i]));
    endtask

    function automatic bit is_mapped(input logic [AW-1:0] a);
        return a[1:0] == 2'b00 && a < 8'(4 * NREG);
    endfunction

    // chg: 0 none, 1 data moves at completion, 2 address moves at completion
    task automatic xfer(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w,
                        input int nwait, input logic ws, input logic ww, input logic wd,
                        input int upd, input int chg);
        @(negedge clk);
        sel = 1; en = 0; rdy = 0; wr = w; addr = a; wdata = d; wen = ws;
        for (int k = 0; k < nwait; k++) begin
            @(negedge clk);
            en = 1; rdy = 0; wen = ww;
        end
        @(negedge clk);
        en = 1; rdy = 1; wen = wd;
        if (chg == 1) wdata = ~d;
        if (chg == 2) addr = a ^ 8'h04;
        if (w && is_mapped(addr) && exp_cnt[addr >> 2] < 255)
            exp_cnt[addr >> 2]++;
        @(negedge clk);
        sel = 0; en = 0; rdy = 0; wen = 0;
        if (upd >= 0) regs[upd] = regs[upd] ^ 16'h5A5A;
        @(posedge clk); #1;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk_err("R12 after reset", 7'd0, 3'd0);
        chk_cnt("R12 counters after reset");
    endtask

    task automatic t_clean();
        xfer(8'h04, 16'h1234, 1, 2, 0, 0, 1, 1, 0);
        chk_err("R8 write with two waits", 7'd0, 3'd0);
        xfer(8'h00, 16'hBEEF, 1, 0, 0, 0, 1, 0, 0);
        xfer(8'h08, 16'h0000, 0, 1, 0, 0, 0, -1, 0);
        chk_err("R8 zero-wait write and read", 7'd0, 3'd0);
        chk_cnt("R11 counts after clean writes");
    endtask

    task automatic t_wait_and_sticky();
        xfer(8'h08, 16'h1111, 1, 1, 0, 1, 1, 2, 0);
        chk_err("R1 commit on wait", 7'b0001001, 3'd1);
        xfer(8'h0C, 16'h2222, 1, 0, 1, 0, 1, 3, 0);
        chk_err("R2 R10 early commit keeps first cause", 7'b0001011, 3'd1);
        xfer(8'h00, 16'h3333, 1, 1, 0, 0, 1, 0, 0);
        chk_err("R9 flags sticky over clean write", 7'b0001011, 3'd1);
        clear_err();
        chk_err("R9 cleared", 7'd0, 3'd0);
    endtask

    task automatic t_single_causes();
        xfer(8'h0C, 16'h4444, 1, 0, 1, 0, 1, 3, 0);
        chk_err("R2 early commit", 7'b0001010, 3'd2);
        clear_err();
        xfer(8'h04, 16'h5555, 1, 1, 0, 0, 0, -1, 0);
        chk_err("R4 missing commit", 7'b0001000, 3'd4);
        clear_err();
        xfer(8'h08, 16'h0000, 0, 0, 0, 0, 0, 2, 0);
        chk_err("R3 change without commit", 7'b0000100, 3'd3);
        clear_err();
        xfer(8'h04, 16'h6666, 1, 1, 0, 0, 1, 1, 1);
        chk_err("R5 data moved", 7'b0010000, 3'd5);
        clear_err();
        xfer(8'h00, 16'h0000, 0, 1, 0, 0, 0, -1, 2);
        chk_err("R5 address moved", 7'b0010000, 3'd5);
        clear_err();
        xfer(8'h04, 16'h0000, 0, 0, 0, 0, 1, -1, 0);
        chk_err("R6 read with write-enable", 7'b0100000, 3'd6);
        clear_err();
        xfer(8'h80, 16'h7777, 1, 0, 0, 0, 1, 0, 0);
        chk_err("R7 unmapped write changes reg", 7'b1000100, 3'd3);
        clear_err();
    endtask

    task automatic t_idle_and_clear_race();
        @(negedge clk); wen = 1;
        @(negedge clk); wen = 0;
        @(posedge clk); #1;
        chk_err("R4 write-enable while unselected", 7'b0001000, 3'd4);
        @(negedge clk);
        sel = 1; en = 1; wr = 0; rdy = 1; wen = 1; addr = 8'h00; err_clr = 1;
        @(negedge clk);
        sel = 0; en = 0; rdy = 0; wen = 0; err_clr = 0;
        @(posedge clk); #1;
        chk_err("R9 R10 error on clear cycle survives", 7'b0100000, 3'd6);
        clear_err();
    endtask

    task automatic t_saturate();
        for (int n = 0; n < 260; n++)
            xfer(8'h0C, 16'(n), 1, 0, 0, 0, 1, 3, 0);
        chk("R11 counter saturates", 32'(commit_cnt[3*CW +: CW]), 32'd255);
        chk_cnt("R11 all counters");
        chk_err("R8 no error over many writes", 7'd0, 3'd0);
    endtask

    task automatic t_reset_again();
        @(negedge clk); wen = 1;
        @(negedge clk); wen = 0; rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        for (int i = 0; i < NREG; i++) exp_cnt[i] = 0;
        @(posedge clk); #1;
        t_reset();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            regs[i] = 16'(i * 16'h0101);
            exp_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        t_reset();
        t_clean();
        t_wait_and_sticky();
        t_single_causes();
        t_idle_and_clear_race();
        t_saturate();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule